// File: doc/BRIEF.md
# Layered Scanline Compositor

The block assembles one video line at a time from five graphics layers: three scrolling tile layers and two single-rectangle sprite layers. For every pixel of a layer it reads a tilemap byte (tile layers only), reads the pattern byte that holds the pixel, and extracts the colour index at the layer's own pixel depth. Index zero is transparent. Any other index is turned into a 24-bit colour through the layer's own palette in memory. Opaque pixels overwrite a line buffer. Layers are drawn in a fixed order, so later layers cover earlier ones.

Host software writes a small set of values per layer before each line: enable, depth, the three memory bases, and scroll or position. It also writes the line number, and then pulses a start input. All memory traffic goes through one synchronous read port with one cycle of latency. When a line is complete the block pulses `line_done` and streams the finished line out, one pixel per clock. The next line can be built at the same time in a second buffer.

Top module: `scl_compositor`

## Requirements
- R1: After reset `busy`, `line_done`, `pix_valid` and `mem_rd` are all low.
- R2: A `line_start` pulse while idle raises `busy` on the next cycle. `line_done` then pulses for exactly one cycle, and `busy` falls in the cycle after it. A `line_start` while busy is ignored and produces no extra `line_done`.
- R3: Every line starts from colour 0 in all LINE_W positions, so a line with every layer disabled reads out as all zero.
- R4: Depth code 0, 1, 2 or 3 (ctrl bits 2:1) selects 1, 2, 4 or 8 bits per pixel. Pixel p of a pattern row lies at bit offset p*bpp of the row. Byte (p*bpp)/8 holds it, taken most-significant first: index = (byte >> (8 - bpp - (p*bpp mod 8))) masked to bpp bits.
- R5: For a tile layer with scroll (sx, sy) on line y at pixel x, let u = (x+sx) mod 256 and v = (y+sy) mod 256. The tile number is the low byte at map_base + ((v>>3) mod 16)*16 + ((u>>3) mod 16). The pattern byte is at pat_base + tile*8*bpp + (v mod 8)*bpp + ((u mod 8)*bpp)/8. All addresses wrap at 12 bits.
- R6: A pixel whose index is 0 leaves the line buffer unchanged.
- R7: Layers are drawn in order tile 0, tile 1, tile 2, sprite 0, sprite 1, so the last opaque pixel at a position wins. A disabled layer (ctrl bit 0 clear) draws nothing.
- R8: An opaque index i gives the 24-bit colour at pal_base + i.
- R9: A sprite layer with position (px, py) draws an 8x8 pattern that uses tile number 0. It covers line y only when py <= y < py+8, and it covers pixels px..px+7. Any of those pixels at px+k >= LINE_W is dropped.
- R10: `pix_valid` rises in the cycle after `line_done` and stays high for exactly LINE_W cycles, carrying pixels 0 to LINE_W-1 in order. A line built during that readout does not disturb it.
- R11: `mem_rd` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address {layer[2:0], field[2:0]}. Layer 7, field 0 is the line number. Fields: 0 ctrl, 1 map base, 2 pattern base, 3 palette base, 4 x scroll or position, 5 y scroll or position |
| cfg_wdata | input | 12 | Register write data |
| line_start | input | 1 | Start building a line |
| busy | output | 1 | Line build in progress |
| line_done | output | 1 | One-cycle pulse when the line is complete |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 12 | Memory read address |
| mem_rdata | input | 24 | Read data, valid one cycle after the request |
| pix_valid | output | 1 | Output pixel valid |
| pix_data | output | 24 | Output pixel colour |

## Verification
A table of line configurations drives the compositor. The table covers a single 1-bit layer, two layers at different depths with small scroll, three 8-bit layers with scroll values that wrap the map, and all five layers together with a sprite clipped at the right edge. Comparing these cases separates errors in depth decoding, bit order and map or pattern address arithmetic from errors in priority and transparency. Further configurations place sprites one line before and one line after their vertical range, and overlap two sprites, which exposes off-by-one range checks and inverted sprite priority. Directed cases cover an all-disabled line for clearing, a start pulse while busy, and a new line built during readout so that a shared or wrongly swapped buffer shows up.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int ADDR_W  = 12;
    localparam int COORD_W = 8;
    localparam int PIX_W   = 24;
    localparam int N_TILE  = 3;
    localparam int N_SPR   = 2;
    localparam int N_LAYER = N_TILE + N_SPR;
    localparam int LYR_W   = $clog2(N_LAYER + 1);

    typedef struct packed {
        logic               en;
        logic [1:0]         depth;
        logic [ADDR_W-1:0]  map_base;
        logic [ADDR_W-1:0]  pat_base;
        logic [ADDR_W-1:0]  pal_base;
        logic [COORD_W-1:0] pos_x;
        logic [COORD_W-1:0] pos_y;
    } layer_cfg_t;

    typedef enum logic [3:0] {
        S_IDLE, S_CLR, S_LAYER, S_MAP, S_TILE, S_PAT, S_UNP, S_WR, S_DONE
    } eng_state_e;
endpackage

// File: rtl/scl_regs.sv
module scl_regs
    import scl_pkg::*;
#(
    parameter int CFG_AW = 6,
    parameter int CFG_DW = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [CFG_AW-1:0]              addr_i,
    input  logic [CFG_DW-1:0]              wdata_i,
    output layer_cfg_t [N_LAYER-1:0]       cfg_o,
    output logic [COORD_W-1:0]             line_o
);
    localparam int FLD_W = 3;
    localparam int SEL_W = CFG_AW - FLD_W;
    localparam logic [SEL_W-1:0] GLOBAL_SEL = '1;

    typedef struct packed {
        layer_cfg_t [N_LAYER-1:0] lyr;
        logic [COORD_W-1:0]       line;
    } regs_t;

    regs_t r_d, r_q;
    logic [SEL_W-1:0] sel;
    logic [FLD_W-1:0] fld;

    assign sel = addr_i[CFG_AW-1:FLD_W];
    assign fld = addr_i[FLD_W-1:0];

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            if (sel == GLOBAL_SEL) begin
                if (fld == '0) r_d.line = wdata_i[COORD_W-1:0];
            end else if (32'(sel) < N_LAYER) begin
                case (fld)
                    3'd0: begin
                        r_d.lyr[sel].en    = wdata_i[0];
                        r_d.lyr[sel].depth = wdata_i[2:1];
                    end
                    3'd1: r_d.lyr[sel].map_base = wdata_i[ADDR_W-1:0];
                    3'd2: r_d.lyr[sel].pat_base = wdata_i[ADDR_W-1:0];
                    3'd3: r_d.lyr[sel].pal_base = wdata_i[ADDR_W-1:0];
                    3'd4: r_d.lyr[sel].pos_x    = wdata_i[COORD_W-1:0];
                    3'd5: r_d.lyr[sel].pos_y    = wdata_i[COORD_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_o  = r_q.lyr;
    assign line_o = r_q.line;
endmodule

// File: rtl/scl_unpack.sv
module scl_unpack (
    input  logic [7:0] byte_i,
    input  logic [1:0] depth_i,
    input  logic [2:0] pos_i,
    output logic [7:0] idx_o
);
    logic [7:0] cand [4];

    for (genvar g = 0; g < 4; g++) begin : g_depth
        localparam int BITS = 1 << g;
        localparam logic [7:0] MASK = 8'((1 << BITS) - 1);
        logic [3:0] shamt;
        assign shamt   = 4'(8 - BITS) - {1'b0, pos_i};
        assign cand[g] = (byte_i >> shamt) & MASK;
    end

    assign idx_o = cand[depth_i];
endmodule

// File: rtl/scl_engine.sv
module scl_engine
    import scl_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int MAP_LG = 4,
    localparam int XW = $clog2(LINE_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  layer_cfg_t [N_LAYER-1:0]  cfg_i,
    input  logic [COORD_W-1:0]        line_i,
    output logic                      mem_rd_o,
    output logic [ADDR_W-1:0]         mem_addr_o,
    input  logic [PIX_W-1:0]          mem_rdata_i,
    output logic                      lb_we_o,
    output logic                      lb_bank_o,
    output logic [XW-1:0]             lb_addr_o,
    output logic [PIX_W-1:0]          lb_data_o,
    output logic                      busy_o,
    output logic                      done_o
);
    typedef struct packed {
        eng_state_e     st;
        logic [LYR_W-1:0] layer;
        logic [XW-1:0]  x;
        logic [7:0]     tile;
        logic           bank;
    } eng_t;

    eng_t q, d;

    layer_cfg_t          lc;
    logic                is_spr, on_line, clipped, last_col, adv;
    logic [COORD_W-1:0]  u, v, srow;
    logic [COORD_W:0]    sdest;
    logic [2:0]          pix, rin;
    logic [7:0]          tnum, idx;
    logic [5:0]          bitoff;
    logic [ADDR_W-1:0]   map_addr, pat_addr, pal_addr;
    logic [XW-1:0]       dest;

    always_comb begin
        lc       = (32'(q.layer) < N_LAYER) ? cfg_i[q.layer] : '0;
        is_spr   = (32'(q.layer) >= N_TILE);
        u        = COORD_W'(q.x) + lc.pos_x;
        v        = line_i + lc.pos_y;
        srow     = line_i - lc.pos_y;
        on_line  = (line_i >= lc.pos_y) && (srow < COORD_W'(8));
        sdest    = {1'b0, lc.pos_x} + (COORD_W+1)'(q.x[2:0]);
        clipped  = (32'(sdest) >= LINE_W);
        pix      = is_spr ? q.x[2:0] : u[2:0];
        rin      = is_spr ? srow[2:0] : v[2:0];
        tnum     = is_spr ? 8'd0 : q.tile;
        bitoff   = {3'b000, pix} << lc.depth;
        map_addr = lc.map_base + ADDR_W'({v[3 +: MAP_LG], u[3 +: MAP_LG]});
        pat_addr = lc.pat_base
                 + ((ADDR_W'(tnum) << 3) << lc.depth)
                 + (ADDR_W'(rin) << lc.depth)
                 + ADDR_W'(bitoff[5:3]);
        dest     = is_spr ? sdest[XW-1:0] : q.x;
        last_col = (q.x == XW'(LINE_W - 1));
    end

    scl_unpack u_unpack (
        .byte_i  (mem_rdata_i[7:0]),
        .depth_i (lc.depth),
        .pos_i   (bitoff[2:0]),
        .idx_o   (idx)
    );

    assign pal_addr = lc.pal_base + ADDR_W'(idx);

    always_comb begin
        d          = q;
        adv        = 1'b0;
        mem_rd_o   = 1'b0;
        mem_addr_o = '0;
        lb_we_o    = 1'b0;
        lb_addr_o  = '0;
        lb_data_o  = '0;
        done_o     = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.x  = '0;
                    d.st = S_CLR;
                end
            end
            S_CLR: begin
                lb_we_o   = 1'b1;
                lb_addr_o = q.x;
                if (last_col) begin
                    d.layer = '0;
                    d.st    = S_LAYER;
                end else begin
                    d.x = q.x + 1'b1;
                end
            end
            S_LAYER: begin
                d.x = '0;
                if (32'(q.layer) == N_LAYER)      d.st = S_DONE;
                else if (!lc.en)                  d.layer = q.layer + 1'b1;
                else if (!is_spr)                 d.st = S_MAP;
                else if (on_line)                 d.st = S_PAT;
                else                              d.layer = q.layer + 1'b1;
            end
            S_MAP: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = map_addr;
                d.st       = S_TILE;
            end
            S_TILE: begin
                d.tile = mem_rdata_i[7:0];
                d.st   = S_PAT;
            end
            S_PAT: begin
                if (is_spr && clipped) begin
                    adv = 1'b1;
                end else begin
                    mem_rd_o   = 1'b1;
                    mem_addr_o = pat_addr;
                    d.st       = S_UNP;
                end
            end
            S_UNP: begin
                if (idx == 8'd0) begin
                    adv = 1'b1;
                end else begin
                    mem_rd_o   = 1'b1;
                    mem_addr_o = pal_addr;
                    d.st       = S_WR;
                end
            end
            S_WR: begin
                lb_we_o   = 1'b1;
                lb_addr_o = dest;
                lb_data_o = mem_rdata_i;
                adv       = 1'b1;
            end
            S_DONE: begin
                done_o = 1'b1;
                d.bank = ~q.bank;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase

        if (adv) begin
            if (is_spr) begin
                if (q.x[2:0] == 3'd7) begin
                    d.layer = q.layer + 1'b1;
                    d.st    = S_LAYER;
                end else begin
                    d.x  = q.x + 1'b1;
                    d.st = S_PAT;
                end
            end else if (last_col) begin
                d.layer = q.layer + 1'b1;
                d.st    = S_LAYER;
            end else begin
                d.x  = q.x + 1'b1;
                d.st = (pix == 3'd7) ? S_MAP : S_PAT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign lb_bank_o = q.bank;
    assign busy_o    = (q.st != S_IDLE);
endmodule

// File: rtl/scl_linebuf.sv
module scl_linebuf
    import scl_pkg::*;
#(
    parameter int LINE_W = 64,
    localparam int XW = $clog2(LINE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              wbank_i,
    input  logic [XW-1:0]     waddr_i,
    input  logic [PIX_W-1:0]  wdata_i,
    input  logic              rd_start_i,
    input  logic              rd_bank_i,
    output logic              pix_valid_o,
    output logic [PIX_W-1:0]  pix_data_o
);
    typedef struct packed {
        logic          active;
        logic          bank;
        logic [XW-1:0] cnt;
    } rd_t;

    logic [PIX_W-1:0] mem_q [2][LINE_W];
    rd_t r_d, r_q;

    always_ff @(posedge clk) begin
        if (we_i) mem_q[wbank_i][waddr_i] <= wdata_i;
    end

    always_comb begin
        r_d = r_q;
        if (r_q.active) begin
            if (r_q.cnt == XW'(LINE_W - 1)) r_d.active = 1'b0;
            r_d.cnt = r_q.cnt + 1'b1;
        end
        if (rd_start_i) begin
            r_d.active = 1'b1;
            r_d.bank   = rd_bank_i;
            r_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pix_valid_o = r_q.active;
    assign pix_data_o  = mem_q[r_q.bank][r_q.cnt];
endmodule

// File: rtl/scl_compositor.sv
module scl_compositor
    import scl_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int MAP_LG = 4,
    parameter int CFG_AW = 6,
    parameter int CFG_DW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    input  logic                line_start,
    output logic                busy,
    output logic                line_done,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [PIX_W-1:0]    mem_rdata,
    output logic                pix_valid,
    output logic [PIX_W-1:0]    pix_data
);
    localparam int XW = $clog2(LINE_W);

    layer_cfg_t [N_LAYER-1:0] cfg;
    logic [COORD_W-1:0]       line_no;
    logic                     lb_we, lb_bank;
    logic [XW-1:0]            lb_addr;
    logic [PIX_W-1:0]         lb_data;

    scl_regs #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg),
        .line_o  (line_no)
    );

    scl_engine #(.LINE_W(LINE_W), .MAP_LG(MAP_LG)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (line_start),
        .cfg_i       (cfg),
        .line_i      (line_no),
        .mem_rd_o    (mem_rd),
        .mem_addr_o  (mem_addr),
        .mem_rdata_i (mem_rdata),
        .lb_we_o     (lb_we),
        .lb_bank_o   (lb_bank),
        .lb_addr_o   (lb_addr),
        .lb_data_o   (lb_data),
        .busy_o      (busy),
        .done_o      (line_done)
    );

    scl_linebuf #(.LINE_W(LINE_W)) u_linebuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (lb_we),
        .wbank_i     (lb_bank),
        .waddr_i     (lb_addr),
        .wdata_i     (lb_data),
        .rd_start_i  (line_done),
        .rd_bank_i   (lb_bank),
        .pix_valid_o (pix_valid),
        .pix_data_o  (pix_data)
    );
endmodule

// File: rtl/scl_compositor_chk.sv
module scl_compositor_chk #(
    parameter int LINE_W = 64
) (
    input logic clk,
    input logic rst_n,
    input logic line_start,
    input logic busy,
    input logic line_done,
    input logic mem_rd,
    input logic pix_valid
);
    localparam int RW = $clog2(LINE_W + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (pix_valid) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !busy) |=> busy);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> (!line_done && !busy));

    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !line_done) |=> busy);

    p_valid_follows_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> pix_valid);

    p_run_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (32'(run_q) < LINE_W));

    p_run_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pix_valid) |-> (32'(run_q) == LINE_W));

    p_no_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd);
endmodule

bind scl_compositor scl_compositor_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .busy       (busy),
    .line_done  (line_done),
    .mem_rd     (mem_rd),
    .pix_valid  (pix_valid)
);

// File: tb/scl_compositor_tb.sv
module scl_compositor_tb_top;
    localparam int W = 64;
    localparam int NV = 8;
    localparam int VB = 71;

    // {line, depth L4..L0, en L4..L0, sx, sy, s0x, s0y, s1x, s1y}
    localparam logic [VB-1:0] VEC [NV] = '{
        {8'd0,   10'b00_00_00_00_00, 5'b00000, 8'd0,   8'd0,   8'd0,  8'd0,   8'd0,  8'd0},
        {8'd0,   10'b00_00_00_00_00, 5'b00001, 8'd0,   8'd0,   8'd0,  8'd0,   8'd0,  8'd0},
        {8'd13,  10'b00_00_00_10_01, 5'b00011, 8'd5,   8'd9,   8'd0,  8'd0,   8'd0,  8'd0},
        {8'd40,  10'b00_00_11_11_11, 5'b00111, 8'd250, 8'd200, 8'd0,  8'd0,   8'd0,  8'd0},
        {8'd40,  10'b01_10_11_01_00, 5'b11111, 8'd17,  8'd3,   8'd10, 8'd38,  8'd61, 8'd33},
        {8'd40,  10'b11_11_00_00_00, 5'b11000, 8'd0,   8'd0,   8'd20, 8'd41,  8'd30, 8'd32},
        {8'd47,  10'b00_11_00_00_00, 5'b11000, 8'd0,   8'd0,   8'd20, 8'd40,  8'd22, 8'd40},
        {8'd255, 10'b10_01_00_10_11, 5'b10101, 8'd127, 8'd77,  8'd0,  8'd250, 8'd56, 8'd250}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        line_start = 1'b0;
    logic        busy, line_done, mem_rd, pix_valid;
    logic [11:0] mem_addr;
    logic [23:0] mem_rdata = '0;
    logic [23:0] pix_data;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    int m_en [5], m_dep [5], m_map [5], m_pat [5], m_pal [5], m_px [5], m_py [5];
    int m_line;
    logic [23:0] exp_a [W];
    logic [23:0] exp_b [W];
    logic [23:0] got_a [W];
    int gaps;

    always #5 clk = ~clk;

    scl_compositor dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .line_start(line_start), .busy(busy),
        .line_done(line_done), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .pix_valid(pix_valid), .pix_data(pix_data)
    );

    function automatic logic [23:0] mem_val(input int a);
        logic [31:0] h;
        logic [23:0] r;
        h = 32'(a & 4095) * 32'd2654435761;
        r = h[31:8];
        if ((a & 4095) % 7 == 3) r[7:0] = 8'h00;
        return r;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mem_val(int'(mem_addr));
    always @(negedge clk) if (line_done) done_cnt++;

    function automatic logic [23:0] ref_pix(input int x);
        logic [23:0] c = 24'h0;
        for (int l = 0; l < 5; l++) begin
            int b, p, r, t, u, v, by, ix;
            if (m_en[l] == 0) continue;
            b = 1 << m_dep[l];
            if (l < 3) begin
                u = (x + m_px[l]) % 256;
                v = (m_line + m_py[l]) % 256;
                t = int'(mem_val(m_map[l] + ((v >> 3) % 16) * 16 + ((u >> 3) % 16)) & 24'hFF);
                p = u % 8;
                r = v % 8;
            end else begin
                if (x < m_px[l] || x >= m_px[l] + 8) continue;
                if (m_line < m_py[l] || m_line >= m_py[l] + 8) continue;
                t = 0;
                p = x - m_px[l];
                r = m_line - m_py[l];
            end
            by = int'(mem_val(m_pat[l] + t * 8 * b + r * b + (p * b) / 8) & 24'hFF);
            ix = (by >> (8 - b - ((p * b) % 8))) & ((1 << b) - 1);
            if (ix != 0) c = mem_val(m_pal[l] + ix);
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic wr(input int l, input int f, input int val);
        cfg_we = 1'b1;
        cfg_addr = 6'((l << 3) | f);
        cfg_wdata = 12'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic apply_vec(input logic [VB-1:0] v);
        m_line = int'(v[70:63]);
        for (int l = 0; l < 5; l++) begin
            m_dep[l] = int'(v[53 + 2*l +: 2]);
            m_en[l]  = int'(v[48 + l]);
            m_map[l] = l * 256;
            m_pat[l] = 12'h400 + l * 12'h180;
            m_pal[l] = 12'hC00 + l * 12'h0C0;
            if (l < 3) begin
                m_px[l] = (int'(v[47:40]) + 3 * l) % 256;
                m_py[l] = (int'(v[39:32]) + 5 * l) % 256;
            end else if (l == 3) begin
                m_px[l] = int'(v[31:24]);
                m_py[l] = int'(v[23:16]);
            end else begin
                m_px[l] = int'(v[15:8]);
                m_py[l] = int'(v[7:0]);
            end
            wr(l, 0, (m_dep[l] << 1) | m_en[l]);
            wr(l, 1, m_map[l]);
            wr(l, 2, m_pat[l]);
            wr(l, 3, m_pal[l]);
            wr(l, 4, m_px[l]);
            wr(l, 5, m_py[l]);
        end
        wr(7, 0, m_line);
    endtask

    task automatic pulse_start();
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            if (line_done) return;
            @(negedge clk);
        end
        check(1'b0, "R2 line_done timeout", 0, 1);
    endtask

    task automatic collect();
        gaps = 0;
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            if (!pix_valid) gaps++;
            got_a[i] = pix_data;
        end
    endtask

    task automatic compare(input string tag, input logic [23:0] e [W]);
        int bad = -1;
        for (int i = 0; i < W; i++) if (bad < 0 && got_a[i] !== e[i]) bad = i;
        check(bad < 0, tag, (bad < 0) ? 0 : got_a[bad], (bad < 0) ? 0 : e[bad]);
        check(gaps == 0, "R10 readout gap", gaps, 0);
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !line_done && !pix_valid && !mem_rd, "R1 reset outputs",
              {busy, line_done, pix_valid, mem_rd}, 0);

        // Vector table walk: R3 R4 R5 R6 R7 R8 R9 R10
        for (int k = 0; k < NV; k++) begin
            apply_vec(VEC[k]);
            for (int i = 0; i < W; i++) exp_a[i] = ref_pix(i);
            d0 = done_cnt;
            pulse_start();
            check(busy, $sformatf("R2 busy after start vec %0d", k), busy, 1);
            wait_done();
            collect();
            compare($sformatf("R4/R5/R6/R7/R8/R9 pixels vec %0d", k), exp_a);
            check(done_cnt - d0 == 1, "R2 one done pulse", done_cnt - d0, 1);
            repeat (3) @(negedge clk);
            check(!busy, "R2 idle after line", busy, 0);
        end

        // R3: all layers off after a busy line
        apply_vec(VEC[0]);
        pulse_start();
        wait_done();
        collect();
        for (int i = 0; i < W; i++) exp_a[i] = 24'h0;
        compare("R3 cleared line", exp_a);

        // R2: start while busy is ignored
        apply_vec(VEC[4]);
        for (int i = 0; i < W; i++) exp_a[i] = ref_pix(i);
        d0 = done_cnt;
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        wait_done();
        collect();
        compare("R2 pixels with ignored start", exp_a);
        repeat (2000) @(negedge clk);
        check(done_cnt - d0 == 1, "R2 ignored start done count", done_cnt - d0, 1);

        // R11: no reads while idle
        begin
            int rds = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mem_rd) rds++;
            end
            check(rds == 0, "R11 idle reads", rds, 0);
        end

        // R10: next line built during readout
        apply_vec(VEC[3]);
        for (int i = 0; i < W; i++) exp_a[i] = ref_pix(i);
        pulse_start();
        wait_done();
        fork
            collect();
            begin
                apply_vec(VEC[6]);
                for (int i = 0; i < W; i++) exp_b[i] = ref_pix(i);
                pulse_start();
            end
        join
        compare("R10 first line during overlap", exp_a);
        wait_done();
        collect();
        compare("R10 second line after overlap", exp_b);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule